// File: doc/BRIEF.md
# Programmable System Clock Divider Tree

This block produces every derived clock of a subsystem as a clock-enable tick plus a registered level waveform. All of it runs in a single fast clock domain. Two tick inputs stand in for the clock sources. `ref_ce` marks each reference-clock cycle. `pll_ce` marks each cycle of the multiplied clock, which comes from an analog PLL modelled outside the block.

The block contains the following dividers:
- A prescaler divides the reference and feeds the PLL. The block also hands the PLL its multiplier code.
- A source selector chooses between the reference and the PLL output. Three system dividers count the selected source.
- A core-clock divider counts the reference.

Every divider has an enable bit and a ratio field, written through a one-cycle write port.

Each divider is a two-state machine with the states `DIV_OFF` and `DIV_RUN`. It has three transitions:
- *start*: `DIV_OFF` to `DIV_RUN` when its enable is seen.
- *stop*: `DIV_RUN` to `DIV_OFF` when the enable is cleared. The period counter is cleared and the outputs go low.
- *wrap*: `DIV_RUN` to `DIV_RUN` at the last tick of a period. This is the only point where a newly written ratio is loaded.

Top module: `clkdiv_tree`

## Requirements
- R1: After reset all dividers are disabled with every ce and level output low, the source selector is in bypass, and `pll_mult` reads 2.
- R2: While a divider is disabled its ce and level outputs stay low, and its period counter is cleared.
- R3: The prescaler (address 2) with ratio code r divides `ref_ce` by r+1 (r = 0..31), giving exactly one ce pulse per r+1 input ticks. The pulse coincides with the last tick of the period, and this holds for any spacing of the input ticks.
- R4: The level output is high for floor(N/2) input ticks of every period of N ticks when N ≥ 2. For N = 1 it stays high while the divider is enabled.
- R5: System dividers (addresses 3, 4, 5 for outputs 0, 1, 2) accept codes 0, 1 and 3 only, meaning divide by 1, 2 and 4. A write carrying any other code is ignored as a whole: the enable and the ratio both keep their previous values.
- R6: Address 0 bit 0 is the source select. With 0 (bypass), the system dividers count `ref_ce` and system divider 0 divides by 1 whatever its code. With 1 they count `pll_ce`, and divider 0 uses its code.
- R7: A multiplier write (address 1, bits 4:0) with a code from 2 to 15 appears on `pll_mult` from the next cycle. Codes 0, 1 and 16 to 31 are ignored.
- R8: The core divider (address 6) with code r divides `ref_ce` by r+1 for every r from 0 to 31.
- R9: A ratio written to a running divider takes effect only at its next period boundary. Every period is either the old or the new length, and every high phase matches one of the two ratios.
- R10: In every divider register, bit 15 is the enable and bits 4:0 are the ratio code. Other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_ce | input | 1 | Reference clock tick |
| pll_ce | input | 1 | PLL output clock tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pll_mult | output | 5 | Multiplier code sent to the PLL |
| pre_ce | output | 1 | Prescaler output tick |
| pre_clk | output | 1 | Prescaler divided level |
| sys_ce | output | 3 | System divider ticks |
| sys_clk | output | 3 | System divider levels |
| core_ce | output | 1 | Core divider tick |
| core_clk | output | 1 | Core divider level |

## Verification
A register write takes hold at the clock edge where `wr_en` is sampled. A divider's state machine acts on the new enable one edge after that, so `pll_mult` is checked one cycle after its write. Divided outputs are measured only after three further cycles of settling. Each ce output is combinational with its input tick in the cycle that ends a period, and the level changes on the edge after a tick. The bench therefore drives the ticks at the falling edge and samples shortly afterwards. It counts pulses and high cycles over windows spanning a whole number of periods, so the totals do not depend on the phase at which the window starts. The ratio-change test instead tracks every pulse gap and every high run across the write.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int RATIO_W = 5;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int EN_BIT  = 15;
    localparam int NUM_SYS = 3;
    localparam int MULT_MIN = 2;
    localparam int MULT_MAX = 15;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE = 3'd0,
        A_MULT = 3'd1,
        A_PRE  = 3'd2,
        A_SYS0 = 3'd3,
        A_SYS1 = 3'd4,
        A_SYS2 = 3'd5,
        A_CORE = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic               en;
        logic [RATIO_W-1:0] code;
    } div_cfg_t;

    function automatic logic sys_code_ok(input logic [RATIO_W-1:0] c);
        return (c == RATIO_W'(0)) || (c == RATIO_W'(1)) || (c == RATIO_W'(3));
    endfunction

    function automatic logic mult_code_ok(input logic [RATIO_W-1:0] c);
        return (c >= RATIO_W'(MULT_MIN)) && (c <= RATIO_W'(MULT_MAX));
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic                     pll_mode,
    output logic [RATIO_W-1:0]       mult,
    output div_cfg_t                 pre_cfg,
    output div_cfg_t [NUM_SYS-1:0]   sys_cfg,
    output div_cfg_t                 core_cfg
);

    logic [RATIO_W-1:0] wd_code;
    logic               wd_en;
    logic               unused_bits;

    assign wd_code     = wr_data[RATIO_W-1:0];
    assign wd_en       = wr_data[EN_BIT];
    assign unused_bits = ^wr_data[EN_BIT-1:RATIO_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_mode <= 1'b0;
        end else if (wr_en && wr_addr == A_MODE) begin
            pll_mode <= wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mult <= RATIO_W'(MULT_MIN);
        end else if (wr_en && wr_addr == A_MULT && mult_code_ok(wd_code)) begin
            mult <= wd_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cfg <= '0;
        end else if (wr_en && wr_addr == A_PRE) begin
            pre_cfg <= '{en: wd_en, code: wd_code};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_cfg <= '0;
        end else if (wr_en && wr_addr == A_CORE) begin
            core_cfg <= '{en: wd_en, code: wd_code};
        end
    end

    for (genvar i = 0; i < NUM_SYS; i++) begin : g_sys_reg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_SYS0) + i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sys_cfg[i] <= '0;
            end else if (wr_en && wr_addr == MY_ADDR && sys_code_ok(wd_code)) begin
                sys_cfg[i] <= '{en: wd_en, code: wd_code};
            end
        end

        AST_SYS_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            sys_code_ok(sys_cfg[i].code)); // R5

        AST_SYS_RESERVED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == MY_ADDR && !sys_code_ok(wd_code)) |=> $stable(sys_cfg[i])); // R5
    end

    AST_MULT_RESERVED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MULT && !mult_code_ok(wd_code)) |=> $stable(mult)); // R7

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int RATIO_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [RATIO_W-1:0] code,
    input  logic               in_ce,
    output logic               out_ce,
    output logic               out_lvl
);

    localparam int CNT_W = RATIO_W;

    typedef enum logic {
        DIV_OFF = 1'b0,
        DIV_RUN = 1'b1
    } div_state_e;

    div_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [RATIO_W-1:0] cur_q, cur_d;
    logic [RATIO_W:0]   period;
    logic [RATIO_W:0]   hi_len;
    logic               at_end;

    assign period = {1'b0, cur_q} + (RATIO_W+1)'(1);
    assign hi_len = (cur_q == '0) ? (RATIO_W+1)'(1) : (period >> 1);
    assign at_end = (cnt_q == cur_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIV_OFF;
            cnt_q   <= '0;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cur_q   <= cur_d;
        end
    end

    // transitions: start, stop, wrap
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cur_d   = cur_q;
        unique case (state_q)
            DIV_OFF: begin
                cnt_d = '0;
                cur_d = code;
                if (en) begin
                    state_d = DIV_RUN;
                end
            end
            DIV_RUN: begin
                if (!en) begin
                    state_d = DIV_OFF;
                    cnt_d   = '0;
                end else if (in_ce) begin
                    if (at_end) begin
                        cnt_d = '0;
                        cur_d = code;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            default: begin
                state_d = DIV_OFF;
            end
        endcase
    end

    // outputs
    always_comb begin
        out_ce  = 1'b0;
        out_lvl = 1'b0;
        unique case (state_q)
            DIV_OFF: begin
                out_ce  = 1'b0;
                out_lvl = 1'b0;
            end
            DIV_RUN: begin
                out_ce  = in_ce && at_end;
                out_lvl = ({1'b0, cnt_q} < hi_len);
            end
            default: begin
                out_ce  = 1'b0;
                out_lvl = 1'b0;
            end
        endcase
    end

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(en)) |=> (!out_ce && !out_lvl)); // R2

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= cur_q); // R3

    AST_RATIO_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DIV_RUN && !(in_ce && at_end)) |=> $stable(cur_q)); // R9

    AST_NO_DOUBLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ce && cur_q != '0 && code != '0) |=> !out_ce); // R3

endmodule

// File: rtl/clkdiv_tree.sv
module clkdiv_tree
    import clkdiv_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ref_ce,
    input  logic         pll_ce,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [15:0]  wr_data,
    output logic [4:0]   pll_mult,
    output logic         pre_ce,
    output logic         pre_clk,
    output logic [2:0]   sys_ce,
    output logic [2:0]   sys_clk,
    output logic         core_ce,
    output logic         core_clk
);

    logic                   pll_mode;
    div_cfg_t               pre_cfg;
    div_cfg_t               core_cfg;
    div_cfg_t [NUM_SYS-1:0] sys_cfg;
    logic                   sys_src_ce;

    clkdiv_regs i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pll_mode (pll_mode),
        .mult     (pll_mult),
        .pre_cfg  (pre_cfg),
        .sys_cfg  (sys_cfg),
        .core_cfg (core_cfg)
    );

    clkdiv_counter #(.RATIO_W(RATIO_W)) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (pre_cfg.en),
        .code    (pre_cfg.code),
        .in_ce   (ref_ce),
        .out_ce  (pre_ce),
        .out_lvl (pre_clk)
    );

    clkdiv_counter #(.RATIO_W(RATIO_W)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (core_cfg.en),
        .code    (core_cfg.code),
        .in_ce   (ref_ce),
        .out_ce  (core_ce),
        .out_lvl (core_clk)
    );

    assign sys_src_ce = pll_mode ? pll_ce : ref_ce;

    for (genvar i = 0; i < NUM_SYS; i++) begin : g_sys
        logic [RATIO_W-1:0] eff_code;

        if (i == 0) begin : g_first
            // bypass skips the first system divider's ratio
            assign eff_code = pll_mode ? sys_cfg[i].code : '0;
        end else begin : g_other
            assign eff_code = sys_cfg[i].code;
        end

        clkdiv_counter #(.RATIO_W(RATIO_W)) i_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (sys_cfg[i].en),
            .code    (eff_code),
            .in_ce   (sys_src_ce),
            .out_ce  (sys_ce[i]),
            .out_lvl (sys_clk[i])
        );

        AST_SYS_FOLLOWS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            sys_ce[i] |-> (pll_mode ? pll_ce : ref_ce)); // R6
    end

endmodule

// File: tb/test_clkdiv_tree.sv
`timescale 1ns/1ps
module test_clkdiv_tree;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_ce, pll_ce;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [4:0]  pll_mult;
    logic        pre_ce, pre_clk, core_ce, core_clk;
    logic [2:0]  sys_ce, sys_clk;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    clkdiv_tree i_clkdiv_tree (
        .clk(clk), .rst_n(rst_n), .ref_ce(ref_ce), .pll_ce(pll_ce),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pll_mult(pll_mult), .pre_ce(pre_ce), .pre_clk(pre_clk),
        .sys_ce(sys_ce), .sys_clk(sys_clk), .core_ce(core_ce), .core_clk(core_clk)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(addr);
        wr_data = 16'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int hi_of(input int n);
        return (n == 1) ? 1 : n / 2;
    endfunction

    // sel: 0 prescaler, 1..3 system divider, 4 core
    task automatic measure(input int sel, input int w, input bit tog,
                           output int pulses, output int highs);
        pulses = 0;
        highs  = 0;
        repeat (w) begin
            @(negedge clk);
            if (tog) ref_ce = ~ref_ce;
            #1;
            case (sel)
                0: begin pulses += int'(pre_ce);  highs += int'(pre_clk);  end
                4: begin pulses += int'(core_ce); highs += int'(core_clk); end
                default: begin
                    pulses += int'(sys_ce[sel-1]);
                    highs  += int'(sys_clk[sel-1]);
                end
            endcase
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int p, h, n, exp_p, exp_h;
        rst_n = 1'b0; ref_ce = 1'b0; pll_ce = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        idle(3);
        #1;
        // R1 reset state
        check_eq("R1", "outputs", int'({pre_ce, pre_clk, sys_ce, sys_clk, core_ce, core_clk}), 0);
        check_eq("R1", "pll_mult", int'(pll_mult), 2);
        rst_n = 1'b1;
        ref_ce = 1'b1;
        idle(2);
        // R1 bypass after reset: system divider 2 counts ref_ce, div 2
        wr(4, 16'h8001);
        idle(3);
        measure(2, 8, 1'b0, p, h);
        check_eq("R1", "bypass default pulses", p, 4);
        wr(4, 0);

        // R3 R4 R10 prescaler sweep
        for (int r = 0; r < 32; r++) begin
            wr(2, 0);
            wr(2, 16'h8000 | 16'h7F00 | r);
            idle(3);
            measure(0, 2 * (r + 1), 1'b0, p, h);
            check_eq("R3", $sformatf("pre pulses r=%0d", r), p, 2);
            check_eq("R4", $sformatf("pre high r=%0d", r), h, 2 * hi_of(r + 1));
        end

        // R2 disabled divider stays low
        wr(2, 16'h8003);
        idle(5);
        wr(2, 16'h0003);
        idle(2);
        measure(0, 20, 1'b0, p, h);
        check_eq("R2", "pre pulses while off", p, 0);
        check_eq("R2", "pre high while off", h, 0);

        // R3 sparse reference ticks (every other cycle), divide by 3
        wr(2, 16'h8002);
        measure(0, 8, 1'b1, p, h);
        measure(0, 12, 1'b1, p, h);
        check_eq("R3", "sparse pulses", p, 2);
        check_eq("R4", "sparse high", h, 4);
        ref_ce = 1'b1;
        wr(2, 0);

        // R8 core sweep
        for (int r = 0; r < 32; r++) begin
            wr(6, 0);
            wr(6, 16'h8000 | r);
            idle(3);
            measure(4, 2 * (r + 1), 1'b0, p, h);
            check_eq("R8", $sformatf("core pulses r=%0d", r), p, 2);
            check_eq("R4", $sformatf("core high r=%0d", r), h, 2 * hi_of(r + 1));
        end
        wr(6, 0);

        // R5 R6 system dividers, both sources, all codes 0..7
        for (int m = 0; m < 2; m++) begin
            wr(0, m);
            ref_ce = (m == 0);
            pll_ce = (m == 1);
            for (int i = 0; i < 3; i++) begin
                for (int c = 0; c < 8; c++) begin
                    wr(3 + i, 0);
                    wr(3 + i, 16'h8000 | c);
                    idle(3);
                    measure(i + 1, 8, 1'b0, p, h);
                    if (c == 0 || c == 1 || c == 3) begin
                        n = (m == 0 && i == 0) ? 1 : c + 1;
                        exp_p = 8 / n;
                        exp_h = exp_p * hi_of(n);
                    end else begin
                        exp_p = 0;
                        exp_h = 0;
                    end
                    check_eq((m == 0 && i == 0) ? "R6" : "R5",
                             $sformatf("sys%0d pulses mode=%0d code=%0d", i, m, c), p, exp_p);
                    check_eq("R5", $sformatf("sys%0d high mode=%0d code=%0d", i, m, c), h, exp_h);
                    wr(3 + i, 0);
                end
            end
        end

        // R9 ratio change on running divider (div 4 -> div 2)
        wr(0, 0);
        ref_ce = 1'b1; pll_ce = 1'b0;
        wr(4, 16'h8003);
        idle(5);
        begin
            int last = -1, gap = 0, bad_gap = 0, run = 0, bad_run = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                wr_en = (k == 6); wr_addr = 3'd4; wr_data = 16'h8001;
                #1;
                if (sys_ce[1]) begin
                    if (last >= 0) begin
                        gap = k - last;
                        if (gap != 2 && gap != 4) bad_gap++;
                    end
                    last = k;
                end
                if (sys_clk[1]) run++;
                else begin
                    if (run != 0 && run != 1 && run != 2) bad_run++;
                    run = 0;
                end
            end
            wr_en = 1'b0;
            check_eq("R9", "bad periods", bad_gap, 0);
            check_eq("R9", "bad high runs", bad_run, 0);
            check_eq("R9", "final period", gap, 2);
        end
        wr(4, 0);

        // R7 multiplier
        wr(1, 7);  #1; check_eq("R7", "mult legal 7", int'(pll_mult), 7);
        wr(1, 1);  #1; check_eq("R7", "mult reserved 1", int'(pll_mult), 7);
        wr(1, 16); #1; check_eq("R7", "mult reserved 16", int'(pll_mult), 7);
        wr(1, 15); #1; check_eq("R7", "mult legal 15", int'(pll_mult), 15);

        finish_run();
    end

endmodule